// File: doc/BRIEF.md
# Supply Reset and Watchdog Controller

This block produces the system reset of a processor subsystem from two causes. The first is a supply-good flag that an external comparator has already digitized. Reset holds while that flag is low. It is released only after the flag has stayed high without a break for a power-up hold time. The second cause is a watchdog. The processor keeps it quiet by pulling the shared chip-select line low from high.

Time is counted in whole milliseconds. A tick-enable input, one clock wide and prescaled elsewhere, advances all counts. The watchdog period comes from a 2-bit select code held in a status register outside this block. When the watchdog expires, it drives a reset pulse of fixed length. The reset leaves the block on two pins of opposite polarity.

Top module: `supply_wdog_reset`

## Requirements
- R1: While the synchronized supply-good flag is low, `rst_out` is 1, within three clock cycles of the flag falling.
- R2: After the synchronous `rst` input, `rst_out` is 1. It goes to 0 on the PWRUP_MS-th tick counted while the supply flag is high, and not before.
- R3: A low level on the supply flag at any time discards the ticks already counted. A fresh run of PWRUP_MS high ticks is then needed for release.
- R4: With the watchdog enabled and no falling edge on `wdi_cs`, reset asserts on the P-th tick after the count starts. This holds whether the line stays high or stays low.
- R5: `wd_sel` selects the period P: 2'b00 gives T_LONG_MS, 2'b01 gives T_MID_MS, 2'b10 gives T_SHORT_MS. 2'b11 turns the watchdog off, and then no amount of ticks ever causes a reset.
- R6: A watchdog reset pulse lasts WDRST_MS ticks. After it ends, the count restarts from zero, so the next expiry needs a full P ticks.
- R7: A falling edge of `wdi_cs`, seen after two synchronizer flops, restarts the count. A rising edge alone does not.
- R8: While the supply holds reset, the watchdog count and any watchdog pulse are held cleared. Ticks counted before the supply loss do not carry over.
- R9: A falling edge on `wdi_cs` during a watchdog reset pulse neither ends nor shortens that pulse.
- R10: If a falling edge and the expiring tick reach the watchdog in the same cycle, the edge wins: no pulse starts, and the count restarts from zero.
- R11: `rst_n_out` is always the inverse of `rst_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; leaves the system reset asserted |
| tick_1ms | input | 1 | One-cycle millisecond tick enable |
| supply_ok | input | 1 | Digitized supply-good flag (asynchronous) |
| wdi_cs | input | 1 | Shared chip-select / watchdog kick line (asynchronous) |
| wd_sel | input | 2 | Watchdog period code: 00 long, 01 mid, 10 short, 11 off |
| rst_out | output | 1 | System reset, active high |
| rst_n_out | output | 1 | System reset, active low |

## Verification
A kick and the watchdog's expiring tick can land in the same clock cycle. The bench provokes this by driving `wdi_cs` low exactly two clock edges before it raises the tick. The synchronized falling edge and the tick then reach the counter together. The expected result is no reset, followed by a full fresh period. A supply loss that arrives while a watchdog count is in progress is also covered: the bench checks that none of the earlier ticks survive the supply-driven reset.

// File: rtl/swr_pkg.sv
`timescale 1ns/1ps
package swr_pkg;

    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    typedef struct packed {
        logic sup_hold;
        logic wd_pulse;
    } rst_cause_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/swr_sync.sv
`timescale 1ns/1ps
module swr_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    logic s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= RST_VAL;
            s2 <= RST_VAL;
        end else begin
            s1 <= d_async;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/swr_supply_timer.sv
`timescale 1ns/1ps
module swr_supply_timer #(
    parameter int unsigned PWRUP_MS = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ok_lvl,
    output logic hold
);
    localparam int unsigned PW = $clog2(PWRUP_MS + 1);
    localparam logic [PW-1:0] DONE = PW'(PWRUP_MS);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !ok_lvl) begin
            cnt <= '0;
        end else if (tick && (cnt != DONE)) begin
            cnt <= cnt + PW'(1);
        end
    end

    assign hold = (cnt != DONE);
endmodule

// File: rtl/swr_watchdog.sv
`timescale 1ns/1ps
module swr_watchdog
    import swr_pkg::*;
#(
    parameter int unsigned T_LONG_MS  = 1400,
    parameter int unsigned T_MID_MS   = 600,
    parameter int unsigned T_SHORT_MS = 200,
    parameter int unsigned WDRST_MS   = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       hold,
    input  logic       wdi_lvl,
    input  logic [1:0] sel,
    output logic       pulse
);
    localparam int unsigned TMAX = max3(T_LONG_MS, T_MID_MS, T_SHORT_MS);
    localparam int unsigned CW   = $clog2(TMAX + 1);
    localparam int unsigned RW   = $clog2(WDRST_MS + 1);
    localparam logic [RW-1:0] PEND = RW'(WDRST_MS - 1);

    logic          prev;
    logic          fall;
    logic          en;
    logic [CW-1:0] lim;
    logic [CW-1:0] cnt;
    logic [RW-1:0] pcnt;

    assign fall = prev & ~wdi_lvl;

    always_comb begin
        en  = 1'b1;
        lim = CW'(1);
        case (wd_sel_e'(sel))
            WD_LONG:  lim = CW'(T_LONG_MS);
            WD_MID:   lim = CW'(T_MID_MS);
            WD_SHORT: lim = CW'(T_SHORT_MS);
            default:  en  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= wdi_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt   <= '0;
            pcnt  <= '0;
            pulse <= 1'b0;
        end else if (pulse) begin
            if (tick) begin
                if (pcnt == PEND) begin
                    pulse <= 1'b0;
                    pcnt  <= '0;
                    cnt   <= '0;
                end else begin
                    pcnt <= pcnt + RW'(1);
                end
            end
        end else if (!en || fall) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt >= lim - CW'(1)) begin
                pulse <= 1'b1;
                pcnt  <= '0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/supply_wdog_reset.sv
`timescale 1ns/1ps
module supply_wdog_reset
    import swr_pkg::*;
#(
    parameter int unsigned PWRUP_MS   = 200,
    parameter int unsigned WDRST_MS   = 200,
    parameter int unsigned T_LONG_MS  = 1400,
    parameter int unsigned T_MID_MS   = 600,
    parameter int unsigned T_SHORT_MS = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1ms,
    input  logic       supply_ok,
    input  logic       wdi_cs,
    input  logic [1:0] wd_sel,
    output logic       rst_out,
    output logic       rst_n_out
);
    logic       ok_lvl;
    logic       wdi_lvl;
    logic       sup_hold;
    logic       wd_pulse;
    rst_cause_t cause;

    swr_sync #(.RST_VAL(1'b0)) u_sync_sup (
        .clk(clk), .rst(rst), .d_async(supply_ok), .q(ok_lvl)
    );

    swr_sync #(.RST_VAL(1'b1)) u_sync_wdi (
        .clk(clk), .rst(rst), .d_async(wdi_cs), .q(wdi_lvl)
    );

    swr_supply_timer #(.PWRUP_MS(PWRUP_MS)) u_sup (
        .clk(clk), .rst(rst), .tick(tick_1ms), .ok_lvl(ok_lvl), .hold(sup_hold)
    );

    swr_watchdog #(
        .T_LONG_MS(T_LONG_MS), .T_MID_MS(T_MID_MS),
        .T_SHORT_MS(T_SHORT_MS), .WDRST_MS(WDRST_MS)
    ) u_wd (
        .clk(clk), .rst(rst), .tick(tick_1ms), .hold(sup_hold),
        .wdi_lvl(wdi_lvl), .sel(wd_sel), .pulse(wd_pulse)
    );

    assign cause.sup_hold = sup_hold;
    assign cause.wd_pulse = wd_pulse;
    assign rst_out   = |cause;
    assign rst_n_out = ~(|cause);
endmodule

// File: rtl/swr_checker.sv
`timescale 1ns/1ps
module swr_checker (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [1:0] wd_sel,
    input logic       rst_out,
    input logic       sup_hold,
    input logic       wd_pulse
);
    AST_RESET_ASSERTS: assert property (@(posedge clk) rst |=> rst_out);               // R2
    AST_SUPPLY_HOLD_RST: assert property (@(posedge clk) disable iff (rst)
        sup_hold |-> rst_out);                                                        // R1
    AST_HOLD_CLEARS_WD: assert property (@(posedge clk) disable iff (rst)
        sup_hold |=> !wd_pulse);                                                      // R8
    AST_OFF_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (wd_sel == 2'b11 && !wd_pulse) |=> !wd_pulse);                                // R5
    AST_PULSE_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (wd_pulse && !tick && !sup_hold) |=> wd_pulse);                               // R9
endmodule

bind supply_wdog_reset swr_checker u_chk (
    .clk(clk), .rst(rst), .tick(tick_1ms), .wd_sel(wd_sel),
    .rst_out(rst_out), .sup_hold(sup_hold), .wd_pulse(wd_pulse)
);

// File: tb/tb_supply_wdog_reset.sv
`timescale 1ns/1ps
module tb_supply_wdog_reset;
    localparam int unsigned PW  = 20;
    localparam int unsigned WDR = 10;
    localparam int unsigned TL  = 40;
    localparam int unsigned TM  = 25;
    localparam int unsigned TS  = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1ms = 1'b0;
    logic       supply_ok = 1'b0;
    logic       wdi_cs = 1'b1;
    logic [1:0] wd_sel = 2'b11;
    logic       rst_out, rst_n_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    supply_wdog_reset #(
        .PWRUP_MS(PW), .WDRST_MS(WDR), .T_LONG_MS(TL), .T_MID_MS(TM), .T_SHORT_MS(TS)
    ) dut (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .supply_ok(supply_ok),
        .wdi_cs(wdi_cs), .wd_sel(wd_sel), .rst_out(rst_out), .rst_n_out(rst_n_out)
    );

    // vector: {sel[1:0], wdi level, expected rst_out, ticks[11:0]}
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        {2'b00, 1'b1, 1'b0, 12'd39},
        {2'b00, 1'b1, 1'b1, 12'd40},
        {2'b01, 1'b0, 1'b0, 12'd24},
        {2'b01, 1'b0, 1'b1, 12'd25},
        {2'b10, 1'b1, 1'b0, 12'd14},
        {2'b10, 1'b0, 1'b1, 12'd15},
        {2'b11, 1'b1, 1'b0, 12'd60},
        {2'b11, 1'b0, 1'b0, 12'd60}
    };

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_1ms = 1'b1;
            @(negedge clk) tick_1ms = 1'b0;
        end
        idle(2);
    endtask

    task automatic check(input string req, input logic exp);
        n_tests++;
        if (rst_out !== exp) begin
            n_fail++;
            $display("FAIL %s: rst_out=%0b expected %0b", req, rst_out, exp);
        end
        n_tests++;
        if (rst_n_out !== ~exp) begin   // R11
            n_fail++;
            $display("FAIL R11 (%s): rst_n_out=%0b expected %0b", req, rst_n_out, ~exp);
        end
    endtask

    task automatic kick();
        wdi_cs = 1'b1; idle(4);
        wdi_cs = 1'b0; idle(4);
    endtask

    task automatic supply_restart();
        supply_ok = 1'b0; idle(4);
        check("R1", 1'b1);
        supply_ok = 1'b1; idle(4);
        ticks(PW - 1);
        check("R2", 1'b1);
        ticks(1);
        check("R2", 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, done=0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        check("R2 reset state", 1'b1);
        rst = 1'b0;
        supply_ok = 1'b1; idle(4);
        ticks(PW - 1);
        check("R2", 1'b1);
        ticks(1);
        check("R2", 1'b0);

        // vector table: R4 / R5 periods
        for (int v = 0; v < NV; v++) begin
            supply_restart();
            wd_sel = VEC[v][15:14];
            wdi_cs = VEC[v][13];
            idle(4);
            ticks(int'(VEC[v][11:0]));
            check("R4/R5 vector", VEC[v][12]);
        end

        // R3: broken supply run restarts the count
        supply_ok = 1'b0; idle(4);
        check("R1", 1'b1);
        supply_ok = 1'b1; idle(4);
        ticks(10);
        supply_ok = 1'b0; idle(4);
        supply_ok = 1'b1; idle(4);
        ticks(PW - 1);
        check("R3", 1'b1);
        ticks(1);
        check("R3", 1'b0);

        // R6: pulse length and fresh count after
        wd_sel = 2'b10; wdi_cs = 1'b1; idle(4);
        supply_restart();
        ticks(TS);
        check("R6 pulse start", 1'b1);
        ticks(WDR - 1);
        check("R6 pulse held", 1'b1);
        ticks(1);
        check("R6 pulse end", 1'b0);
        ticks(TS - 1);
        check("R6 fresh count", 1'b0);
        ticks(1);
        check("R6 next expiry", 1'b1);

        // R9: kick during pulse does not shorten it
        supply_restart();
        ticks(TS);
        check("R9 pulse start", 1'b1);
        ticks(5);
        kick();
        ticks(WDR - 6);
        check("R9 pulse held", 1'b1);
        ticks(1);
        check("R9 pulse end", 1'b0);

        // R7: falling edge restarts, rising edge alone does not
        supply_restart();
        wdi_cs = 1'b1; idle(4);
        ticks(10);
        kick();
        ticks(TS - 1);
        check("R7 fall restarts", 1'b0);
        ticks(1);
        check("R7 expiry", 1'b1);
        supply_restart();
        wdi_cs = 1'b0; idle(4);
        ticks(10);
        wdi_cs = 1'b1; idle(4);
        ticks(TS - 11);
        check("R7 rise ignored", 1'b0);
        ticks(1);
        check("R7 rise ignored", 1'b1);

        // R10: kick coincides with expiring tick
        supply_restart();
        wdi_cs = 1'b1; idle(4);
        ticks(TS - 1);
        @(negedge clk) wdi_cs = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk) tick_1ms = 1'b1;
        @(negedge clk) tick_1ms = 1'b0;
        idle(2);
        check("R10 kick wins", 1'b0);
        ticks(TS - 1);
        check("R10 fresh count", 1'b0);
        ticks(1);
        check("R10 expiry", 1'b1);

        // R8: supply loss discards watchdog progress
        supply_restart();
        wdi_cs = 1'b1; idle(4);
        ticks(10);
        supply_ok = 1'b0; idle(4);
        check("R8 supply hold", 1'b1);
        supply_ok = 1'b1; idle(4);
        ticks(PW);
        check("R8 release", 1'b0);
        ticks(TS - 1);
        check("R8 cleared", 1'b0);
        ticks(1);
        check("R8 expiry", 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule